// File: doc/BRIEF.md
# USB Line Receiver with Preamble Rate Switching

This block sits behind a pair of already synchronised D+ and D− inputs. It runs on an oversampling clock and turns the line levels back into a packet bit stream for a low-speed or full-speed USB link. Each clock it converts the line pair into a bus symbol. It finds the start of a packet on an idle-to-K change, centres a sampling point in every bit cell and decodes NRZI into data bits, which it presents as a single-cycle strobe with data. A single-ended-zero sample opens end-of-packet handling, which either reports a clean end of packet or flags a malformed one.

On a full-speed segment, a host can announce a low-speed packet by sending a sync byte and then the preamble token. The receiver recognises that 16-bit opening while the bits arrive. It reports a pseudo end of packet and returns to idle. It then stays in a preamble mode, where it uses the low-speed bit time but keeps full-speed J/K polarity, until it is reset. The bit period and the sampling phase are held as fixed-point clock counts and trimmed on data transitions.

Top module: `usb_line_rx`

## Requirements
- R1: The pin pair {dp,dm} maps as 00 = SE0 and 11 = SE1. With full-speed polarity, 10 = J and 01 = K. With plain low-speed polarity (low_speed=1 and not in preamble mode), 01 = J and 10 = K.
- R2: In idle, `sop` pulses only when a K symbol directly follows a J symbol. A K that follows SE0 starts nothing, and no bit strobes appear.
- R3: The bit time is FS_OVS clocks at full speed and FS_OVS*LS_RATIO clocks at low speed. The first bit strobe appears half a bit time plus 3 clocks after the J-to-K change on the pins. Later strobes follow about one bit time apart.
- R4: Each sample that is not SE0 gives one `bit_valid` pulse. `bit_data` is 0 when the sampled symbol differs from the previous sample and 1 when it is the same. The previous sample counts as J at the start of a packet.
- R5: SE0 samples followed by a J sample pulse `eop` once, without `eop_err`.
- R6: SE0 samples followed by a K or SE1 sample pulse `eop_err` once, without `eop`.
- R7: After an end of packet, a new packet can start only after J has been held for one full bit time. A K that arrives before that starts no packet.
- R8: If the first 16 decoded bits of a packet, in arrival order, are 0000000100111100, then `eop` pulses and `pre_mode` rises. The receiver returns to idle and takes following packets at the low-speed bit time with full-speed polarity.
- R9: Every start of packet reloads the nominal bit period. As a result, identical packets sent one after another produce strobes with identical timing.
- R10: While reset is held and after it, every event output and `pre_mode` is 0. Reset also leaves preamble mode.
- R11: Only an exact match of the first 16 bits enters preamble mode. An opening that differs in any bit leaves `pre_mode` at 0 and the packet ends normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| low_speed | input | 1 | Starting signalling: 1 = low speed, 0 = full speed |
| dp | input | 1 | Synchronised D+ level |
| dm | input | 1 | Synchronised D− level |
| bit_valid | output | 1 | One-cycle strobe for a decoded bit |
| bit_data | output | 1 | Decoded bit, valid with `bit_valid` |
| sop | output | 1 | Start-of-packet pulse |
| eop | output | 1 | End-of-packet pulse (also the pseudo end after a preamble opening) |
| eop_err | output | 1 | Malformed end-of-packet pulse |
| pre_mode | output | 1 | Preamble mode: low-speed timing with full-speed polarity |

## Verification
The hardest state to reach is the switch into preamble mode and the packet that follows it. That packet only decodes if the rate has changed while the polarity stays the same. The bench sends the exact 16-bit opening at full-speed timing, idles on the full-speed J, and then sends a packet at low-speed timing with full-speed polarity. It checks the strobe delay and the bits of that packet. A near-miss opening after a reset, and a short J after an end of packet followed by an early K, cover the cases just outside those two paths.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;

    typedef enum logic [1:0] {
        SYM_SE0 = 2'b00,
        SYM_J   = 2'b01,
        SYM_K   = 2'b10,
        SYM_SE1 = 2'b11
    } sym_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_EOP,
        ST_WAIT
    } rx_state_t;

    typedef struct packed {
        logic sop;
        logic eop;
        logic eop_err;
        logic bit_valid;
        logic bit_data;
    } rx_evt_t;

    localparam int          OPEN_LEN   = 16;
    localparam logic [15:0] PRE_OPEN   = 16'b0000_0001_0011_1100;

    // Line pair to symbol; swap_jk selects plain low-speed polarity.
    function automatic sym_t line_to_sym(input logic dp_i, input logic dm_i,
                                         input logic swap_jk);
        sym_t s;
        case ({dp_i, dm_i})
            2'b00:   s = SYM_SE0;
            2'b11:   s = SYM_SE1;
            2'b10:   s = swap_jk ? SYM_K : SYM_J;
            default: s = swap_jk ? SYM_J : SYM_K;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/usbrx_line_sym.sv
module usbrx_line_sym
    import usbrx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic dp,
    input  logic dm,
    input  logic swap_jk,
    output sym_t sym,
    output sym_t edge_sym,
    output logic jk_edge
);

    sym_t sym_q, sym_d1, edge_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_q  <= SYM_J;
            sym_d1 <= SYM_J;
            edge_q <= SYM_J;
        end else begin
            sym_q  <= line_to_sym(dp, dm, swap_jk);
            sym_d1 <= sym_q;
            if (sym_q != sym_d1)
                edge_q <= sym_q;
        end
    end

    assign sym      = sym_q;
    assign edge_sym = edge_q;
    assign jk_edge  = (sym_d1 == SYM_J) && (sym_q == SYM_K);

    AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (sym_q != sym_d1) |=> (edge_q == $past(sym_q)));  // R9

endmodule

// File: rtl/usbrx_bit_timer.sv
module usbrx_bit_timer #(
    parameter int FS_OVS = 16,
    parameter int LS_OVS = 128,
    parameter int FRAC   = 10,
    parameter int PW     = 19,
    localparam int PIW   = PW - FRAC
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           ls_rate,
    input  logic           run,
    input  logic           adj_en,
    input  logic           adj_later,
    output logic           sample,
    output logic [PIW-1:0] period_int
);

    localparam logic [PW-1:0] ONE    = PW'(1) << FRAC;
    localparam logic [PW-1:0] NOM_FS = PW'(FS_OVS) << FRAC;
    localparam logic [PW-1:0] NOM_LS = PW'(LS_OVS) << FRAC;

    logic [PW-1:0] period_q, remain_q;
    logic [PW-1:0] nominal, step, shift, period_n, reload;

    always_comb begin
        nominal  = ls_rate ? NOM_LS : NOM_FS;
        step     = period_q >> 10;                       // about 0.1 %
        shift    = (period_q >> 7) + (period_q >> 9);    // about 1 %
        sample   = run && !start && (remain_q[PW-1:FRAC] == '0);
        period_n = period_q;
        if (adj_en)
            period_n = adj_later ? period_q + step : period_q - step;
        reload = remain_q + period_n - ONE;
        if (adj_en)
            reload = adj_later ? reload + shift : reload - shift;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= NOM_FS;
            remain_q <= '0;
        end else if (start) begin
            period_q <= nominal;
            remain_q <= nominal >> 1;
        end else if (run) begin
            if (sample) begin
                period_q <= period_n;
                remain_q <= reload;
            end else begin
                remain_q <= remain_q - ONE;
            end
        end
    end

    assign period_int = period_q[PW-1:FRAC];

    AST_SAMPLE_GAP: assert property (@(posedge clk) disable iff (rst)
        sample |=> !sample);  // R3
    AST_TRIM_LONGER: assert property (@(posedge clk) disable iff (rst)
        (sample && adj_en && adj_later) |=> (period_q > $past(period_q)));  // R9
    AST_TRIM_SHORTER: assert property (@(posedge clk) disable iff (rst)
        (sample && adj_en && !adj_later) |=> (period_q < $past(period_q)));  // R9
    AST_START_NOMINAL: assert property (@(posedge clk) disable iff (rst)
        start |=> (period_q == (ls_rate ? NOM_LS : NOM_FS)) || $past(ls_rate) != ls_rate);  // R9

endmodule

// File: rtl/usbrx_ctrl.sv
module usbrx_ctrl
    import usbrx_pkg::*;
#(
    parameter int PIW = 9
) (
    input  logic           clk,
    input  logic           rst,
    input  sym_t           sym,
    input  sym_t           edge_sym,
    input  logic           jk_edge,
    input  logic           sample,
    input  logic [PIW-1:0] period_int,
    output logic           start,
    output logic           run,
    output logic           adj_en,
    output logic           adj_later,
    output logic           pre_mode,
    output rx_evt_t        evt
);

    localparam int CNT_W = $clog2(OPEN_LEN + 1);

    rx_state_t          st_q;
    sym_t               prev_q;
    logic [OPEN_LEN-1:0] hist_q, hist_n;
    logic [CNT_W-1:0]   cnt_q;
    logic [PIW-1:0]     jcnt_q;
    logic               pre_q;
    logic               nrzi;
    rx_evt_t            evt_q;

    always_comb begin
        nrzi      = (sym == prev_q);
        hist_n    = {hist_q[OPEN_LEN-2:0], nrzi};
        start     = (st_q == ST_IDLE) && jk_edge;
        run       = (st_q == ST_DATA) || (st_q == ST_EOP);
        adj_en    = sample && (st_q == ST_DATA) && !nrzi &&
                    (sym != SYM_SE0) &&
                    ((edge_sym == SYM_J) || (edge_sym == SYM_K));
        adj_later = (edge_sym != sym);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            prev_q <= SYM_J;
            hist_q <= '0;
            cnt_q  <= '0;
            jcnt_q <= '0;
            pre_q  <= 1'b0;
            evt_q  <= '0;
        end else begin
            evt_q <= '0;
            unique case (st_q)
                ST_IDLE: begin
                    jcnt_q <= '0;
                    if (jk_edge) begin
                        evt_q.sop <= 1'b1;
                        st_q      <= ST_DATA;
                        prev_q    <= SYM_J;
                        hist_q    <= '0;
                        cnt_q     <= '0;
                    end
                end
                ST_DATA: begin
                    if (sample) begin
                        prev_q <= sym;
                        if (sym == SYM_SE0) begin
                            st_q <= ST_EOP;
                        end else begin
                            evt_q.bit_valid <= 1'b1;
                            evt_q.bit_data  <= nrzi;
                            if (cnt_q < CNT_W'(OPEN_LEN)) begin
                                hist_q <= hist_n;
                                cnt_q  <= cnt_q + 1'b1;
                                if (cnt_q == CNT_W'(OPEN_LEN - 1) && hist_n == PRE_OPEN) begin
                                    evt_q.eop <= 1'b1;
                                    st_q      <= ST_IDLE;
                                    pre_q     <= 1'b1;
                                    prev_q    <= SYM_J;
                                end
                            end
                        end
                    end
                end
                ST_EOP: begin
                    jcnt_q <= '0;
                    if (sample) begin
                        prev_q <= sym;
                        if (sym == SYM_J) begin
                            evt_q.eop <= 1'b1;
                            st_q      <= ST_WAIT;
                        end else if (sym != SYM_SE0) begin
                            evt_q.eop_err <= 1'b1;
                            st_q          <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (sym == SYM_J) begin
                        if (({1'b0, jcnt_q} + (PIW+1)'(1)) >= {1'b0, period_int}) begin
                            st_q   <= ST_IDLE;
                            jcnt_q <= '0;
                        end else begin
                            jcnt_q <= jcnt_q + 1'b1;
                        end
                    end else begin
                        jcnt_q <= '0;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign pre_mode = pre_q;
    assign evt      = evt_q;

    AST_SOP_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        evt_q.sop |-> $past(st_q == ST_IDLE));  // R2
    AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt_q.sop, evt_q.eop, evt_q.eop_err}));  // R6
    AST_ERR_TO_WAIT: assert property (@(posedge clk) disable iff (rst)
        evt_q.eop_err |-> (st_q == ST_WAIT));  // R6
    AST_EOP_TARGET: assert property (@(posedge clk) disable iff (rst)
        evt_q.eop |-> ((st_q == ST_WAIT) || (st_q == ST_IDLE && pre_q)));  // R5
    AST_PRE_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(pre_q) |-> pre_q);  // R8
    AST_BIT_ONLY_DATA: assert property (@(posedge clk) disable iff (rst)
        evt_q.bit_valid |-> $past(st_q == ST_DATA));  // R4

endmodule

// File: rtl/usb_line_rx.sv
module usb_line_rx
    import usbrx_pkg::*;
#(
    parameter int FS_OVS   = 16,
    parameter int LS_RATIO = 8,
    parameter int FRAC     = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic low_speed,
    input  logic dp,
    input  logic dm,
    output logic bit_valid,
    output logic bit_data,
    output logic sop,
    output logic eop,
    output logic eop_err,
    output logic pre_mode
);

    localparam int LS_OVS = FS_OVS * LS_RATIO;
    localparam int PW     = $clog2(LS_OVS * 2) + FRAC + 1;
    localparam int PIW    = PW - FRAC;

    sym_t           sym, edge_sym;
    logic           jk_edge, start, run, adj_en, adj_later, sample;
    logic           pre_q;
    logic [PIW-1:0] period_int;
    rx_evt_t        evt;

    usbrx_line_sym i_line_sym (
        .clk      (clk),
        .rst      (rst),
        .dp       (dp),
        .dm       (dm),
        .swap_jk  (low_speed && !pre_q),
        .sym      (sym),
        .edge_sym (edge_sym),
        .jk_edge  (jk_edge)
    );

    usbrx_bit_timer #(
        .FS_OVS (FS_OVS),
        .LS_OVS (LS_OVS),
        .FRAC   (FRAC),
        .PW     (PW)
    ) i_bit_timer (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .ls_rate    (low_speed || pre_q),
        .run        (run),
        .adj_en     (adj_en),
        .adj_later  (adj_later),
        .sample     (sample),
        .period_int (period_int)
    );

    usbrx_ctrl #(
        .PIW (PIW)
    ) i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .sym        (sym),
        .edge_sym   (edge_sym),
        .jk_edge    (jk_edge),
        .sample     (sample),
        .period_int (period_int),
        .start      (start),
        .run        (run),
        .adj_en     (adj_en),
        .adj_later  (adj_later),
        .pre_mode   (pre_q),
        .evt        (evt)
    );

    assign bit_valid = evt.bit_valid;
    assign bit_data  = evt.bit_data;
    assign sop       = evt.sop;
    assign eop       = evt.eop;
    assign eop_err   = evt.eop_err;
    assign pre_mode  = pre_q;

endmodule

// File: tb/test_usb_line_rx.sv
module test_usb_line_rx;

    localparam int CLK_PERIOD = 10;
    localparam int FS = 16;
    localparam int LS = 128;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst, low_speed, dp, dm;
    logic bit_valid, bit_data, sop, eop, eop_err, pre_mode;

    int checks = 0, failures = 0;
    int cyc = 0, k_cyc = 0, first_cyc = 0, second_cyc = 0;
    int cap_n = 0, n_sop = 0, n_eop = 0, n_err = 0;
    logic [63:0] cap_bits = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_line_rx i_usb_line_rx (
        .clk(clk), .rst(rst), .low_speed(low_speed), .dp(dp), .dm(dm),
        .bit_valid(bit_valid), .bit_data(bit_data), .sop(sop), .eop(eop),
        .eop_err(eop_err), .pre_mode(pre_mode)
    );

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (!rst) begin
            if (bit_valid) begin
                if (cap_n == 0) first_cyc = cyc;
                if (cap_n == 1) second_cyc = cyc;
                cap_bits = {cap_bits[62:0], bit_data};
                cap_n++;
            end
            if (sop)     n_sop++;
            if (eop)     n_eop++;
            if (eop_err) n_err++;
        end
    end

    task automatic chk(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic chk_rng(input string req, input int actual, input int lo, input int hi);
        checks++;
        if (actual < lo || actual > hi) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, actual, lo, hi);
        end
    endtask

    function automatic logic [1:0] j_pins(input bit inv);
        return inv ? 2'b01 : 2'b10;
    endfunction

    function automatic logic [1:0] k_pins(input bit inv);
        return inv ? 2'b10 : 2'b01;
    endfunction

    task automatic hold(input logic [1:0] pins, input int n);
        {dp, dm} = pins;
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_caps();
        cap_n = 0; cap_bits = '0; n_sop = 0; n_eop = 0; n_err = 0;
    endtask

    task automatic send_bits(input logic [31:0] bits, input int n, input int ovs, input bit inv);
        bit lvl_k = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (bits[n-1-i] == 1'b0) lvl_k = ~lvl_k;
            if (i == 0) k_cyc = cyc;
            hold(lvl_k ? k_pins(inv) : j_pins(inv), ovs);
        end
    endtask

    task automatic send_eop(input int ovs, input bit inv);
        hold(2'b00, 2 * ovs);
        hold(j_pins(inv), 3 * ovs);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        low_speed = 1'b0;
        {dp, dm} = 2'b10;
        repeat (4) @(negedge clk);
        chk("R10 reset bit_valid", int'(bit_valid), 0);
        chk("R10 reset pre_mode", int'(pre_mode), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 after reset events", int'({sop, eop, eop_err, bit_valid}), 0);
    endtask

    task automatic t_fs_packet();
        int d1;
        clear_caps();
        send_bits(32'h01A5, 16, FS, 1'b0);
        send_eop(FS, 1'b0);
        chk("R4 fs bit count", cap_n, 16);
        chk("R4 fs bits", int'(cap_bits[15:0]), 'h01A5);
        chk("R2 fs sop", n_sop, 1);
        chk("R5 fs eop", n_eop, 1);
        chk("R5 fs no eop_err", n_err, 0);
        chk_rng("R3 fs first strobe delay", first_cyc - k_cyc, FS/2 + 2, FS/2 + 4);
        chk_rng("R3 fs strobe spacing", second_cyc - first_cyc, FS - 1, FS + 1);
        d1 = first_cyc - k_cyc;
        // R9: a second identical packet starts from the nominal period again
        clear_caps();
        hold(2'b10, 2 * FS);
        send_bits(32'h01A5, 16, FS, 1'b0);
        send_eop(FS, 1'b0);
        chk("R9 repeat delay", first_cyc - k_cyc, d1);
        chk("R9 repeat bits", int'(cap_bits[15:0]), 'h01A5);
    endtask

    task automatic t_ls_packet();
        clear_caps();
        low_speed = 1'b1;
        hold(j_pins(1'b1), 2 * LS);
        send_bits(32'h01A5, 16, LS, 1'b1);
        send_eop(LS, 1'b1);
        chk("R1 ls inverted bits", int'(cap_bits[15:0]), 'h01A5);
        chk("R1 ls eop", n_eop, 1);
        chk_rng("R3 ls first strobe delay", first_cyc - k_cyc, LS/2 + 2, LS/2 + 4);
        chk("R10 ls no pre_mode", int'(pre_mode), 0);
        low_speed = 1'b0;
        hold(j_pins(1'b0), 2 * FS);
    endtask

    task automatic t_sop_rules();
        clear_caps();
        hold(2'b00, FS);
        hold(k_pins(1'b0), FS);
        hold(j_pins(1'b0), 3 * FS);
        chk("R2 SE0 then K no sop", n_sop, 0);
        chk("R2 no strobes", cap_n, 0);
    endtask

    task automatic t_eop_err();
        clear_caps();
        send_bits(32'h01, 8, FS, 1'b0);
        hold(2'b00, FS);
        hold(k_pins(1'b0), FS);
        hold(j_pins(1'b0), 3 * FS);
        chk("R6 eop_err", n_err, 1);
        chk("R6 no eop", n_eop, 0);
    endtask

    task automatic t_wait_idle();
        clear_caps();
        send_bits(32'h01, 8, FS, 1'b0);
        hold(2'b00, 2 * FS);
        hold(j_pins(1'b0), 12);
        hold(k_pins(1'b0), FS);
        hold(j_pins(1'b0), 3 * FS);
        chk("R7 early K no sop", n_sop, 1);
        chk("R7 eop", n_eop, 1);
        chk("R7 no err", n_err, 0);
        send_bits(32'h01, 8, FS, 1'b0);
        send_eop(FS, 1'b0);
        chk("R7 later packet sop", n_sop, 2);
    endtask

    task automatic t_pre();
        clear_caps();
        send_bits(32'b0000000100111100, 16, FS, 1'b0);
        hold(j_pins(1'b0), 2 * FS);
        chk("R8 pre strobes", cap_n, 16);
        chk("R8 pseudo eop", n_eop, 1);
        chk("R8 pre_mode", int'(pre_mode), 1);
        clear_caps();
        send_bits(32'h01C3, 16, LS, 1'b0);
        send_eop(LS, 1'b0);
        chk("R8 ls-rate fs-polarity bits", int'(cap_bits[15:0]), 'h01C3);
        chk_rng("R8 low-speed delay", first_cyc - k_cyc, LS/2 + 2, LS/2 + 4);
        chk("R8 eop", n_eop, 1);
        chk("R8 pre_mode stays", int'(pre_mode), 1);
    endtask

    task automatic t_near_miss();
        clear_caps();
        send_bits(32'b0000000100111101, 16, FS, 1'b0);
        send_eop(FS, 1'b0);
        chk("R11 near miss pre_mode", int'(pre_mode), 0);
        chk("R11 near miss eop", n_eop, 1);
        chk("R11 near miss bits", int'(cap_bits[15:0]), 'b0000000100111101);
    endtask

    task automatic run_all();
        do_reset();
        t_fs_packet();
        t_ls_packet();
        t_sop_rules();
        t_eop_err();
        t_wait_idle();
        t_pre();
        do_reset();
        t_near_miss();
    endtask

    initial begin
        rst = 1'b1; low_speed = 1'b0; dp = 1'b1; dm = 1'b0;
        @(negedge clk);
        fork
            run_all();
            begin
                repeat (WATCHDOG) @(posedge clk);
                failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule